// File: doc/BRIEF.md
# Paced Interrupt Aggregator

This block collects single-cycle event pulses from several channels and merges them into four CPU interrupt lines. The categories are receive, transmit, receive-threshold and miscellaneous. Each channel of each category has its own enable bit. Only enabled channels contribute to the line of their category.

The receive and transmit lines can be rate limited. A prescaler divides the system clock into a window tick, normally once per millisecond. Within each window a direction fires at most its programmed number of interrupts. Events that arrive after that limit are folded into one held request, which is delivered on the next tick. Threshold and miscellaneous events are never rate limited.

Software programs the window length and both maximum counts before it enables any source. It then switches pacing on or off globally. Every interrupt line is a registered pulse that is high for one cycle per delivered interrupt.

Top module: `paced_irq_agg`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, all four interrupt outputs are low.
- R2: With `tick_cycles_i` = N (N ≥ 1), a window tick occurs once every N clock cycles. A direction that is saturated with `max` = 1 therefore delivers its interrupts exactly N cycles apart.
- R3: A receive or transmit event on a channel whose enable bit is 0 never produces an interrupt. If every enable bit of a direction is 0, any held request of that direction is discarded and is not delivered later.
- R4: With `pace_en_i` = 0, an event on an enabled channel raises its receive or transmit line in the next cycle. This happens on every event, with no limit.
- R5: With pacing on and a maximum M > 0, a direction delivers at most M interrupts per window. A continuous event stream yields exactly M interrupts per window.
- R6: An event that arrives after the limit is reached is held. It is delivered in the cycle after the next tick. Several held events collapse into a single interrupt.
- R7: A maximum count of 0 disables pacing for that direction only. Its events then pass through in the next cycle, as under R4.
- R8: A threshold or miscellaneous event on an enabled channel raises its line in the next cycle, whether pacing is on or off, with no rate limit. Disabled channels have no effect.
- R9: The receive and transmit directions keep separate window counts. Saturating one direction does not change how many interrupts the other delivers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_evt_i | input | NUM_CH | Receive event pulses, one per channel |
| tx_evt_i | input | NUM_CH | Transmit event pulses, one per channel |
| thr_evt_i | input | NUM_CH | Receive-threshold event pulses, one per channel |
| misc_evt_i | input | MISC_W | Miscellaneous event pulses |
| rx_en_i | input | NUM_CH | Receive channel enables |
| tx_en_i | input | NUM_CH | Transmit channel enables |
| thr_en_i | input | NUM_CH | Threshold channel enables |
| misc_en_i | input | MISC_W | Miscellaneous source enables |
| pace_en_i | input | 1 | Global pacing on/off |
| rx_max_i | input | CNT_W | Receive interrupts allowed per window (0 = unpaced) |
| tx_max_i | input | CNT_W | Transmit interrupts allowed per window (0 = unpaced) |
| tick_cycles_i | input | PRESC_W | Clock cycles per window |
| rx_irq_o | output | 1 | Receive interrupt pulse |
| tx_irq_o | output | 1 | Transmit interrupt pulse |
| thr_irq_o | output | 1 | Receive-threshold interrupt pulse |
| misc_irq_o | output | 1 | Miscellaneous interrupt pulse |

## Verification
The assertions assume that `tick_cycles_i` and the maximum counts are stable while a window is running. They also assume that event inputs are clean, synchronous pulses. The one rule that depends on timing is the tick-spacing check, which is waived when the window length is 1.

The stimulus writes the window length once, right after reset, and never changes it. It changes maximum counts and enables only between scenarios, or while a direction is known to be saturated. Scenarios that depend on where the window boundary falls first align to it: they stream events with `max` = 1 until a tick-driven delivery is observed.

// File: rtl/paced_irq_pkg.sv
package paced_irq_pkg;
  localparam int unsigned NUM_DIR = 2;
  localparam int unsigned DIR_RX  = 0;
  localparam int unsigned DIR_TX  = 1;

  typedef enum logic [1:0] {
    CAT_RX   = 2'd0,
    CAT_TX   = 2'd1,
    CAT_THR  = 2'd2,
    CAT_MISC = 2'd3
  } irq_cat_e;
endpackage

// File: rtl/window_timer.sv
module window_timer #(
  parameter int unsigned PRESC_W = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PRESC_W-1:0] tick_cycles_i,
  output logic               tick_o
);
  logic [PRESC_W-1:0] cnt_q;
  logic [PRESC_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  // zero behaves like one: tick every cycle
  assign tick_o  = cnt_inc >= {1'b0, tick_cycles_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_inc[PRESC_W-1:0];
  end

  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && tick_cycles_i > 1) |=> (!tick_o || tick_cycles_i <= 1)); // R2
endmodule

// File: rtl/evt_gate.sv
module evt_gate #(
  parameter int unsigned W       = 8,
  parameter bit          REG_OUT = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] en_i,
  output logic         hit_o,
  output logic         any_en_o
);
  logic hit_c;

  assign hit_c    = |(evt_i & en_i);
  assign any_en_o = |en_i;

  if (REG_OUT) begin : g_reg
    logic hit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hit_q <= 1'b0;
      else         hit_q <= hit_c;
    end
    assign hit_o = hit_q;

    AST_GATE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i == '0) |=> !hit_o); // R8
    AST_GATE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((evt_i & en_i) != '0) |=> hit_o); // R8
  end else begin : g_comb
    assign hit_o = hit_c;
  end
endmodule

// File: rtl/rate_pacer.sv
module rate_pacer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             pace_en_i,
  input  logic [CNT_W-1:0] max_i,
  input  logic             evt_i,
  input  logic             any_en_i,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, irq_q;
  logic             active, want, allow, fire;

  assign active = pace_en_i && (max_i != '0);
  assign want   = evt_i | pend_q;
  assign allow  = !active || tick_i || (cnt_q < max_i);
  assign fire   = want && allow && any_en_i;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i)
      cnt_d = (fire && active) ? CNT_W'(1) : '0;
    else if (fire && active && cnt_q != '1)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= want && !allow && any_en_i;
      irq_q  <= fire;
    end
  end

  assign irq_o = irq_q;

  AST_CAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !tick_i && cnt_q >= max_i) |=> !irq_o); // R5
  AST_TICK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && pend_q && any_en_i) |=> irq_o); // R6
  AST_DROP_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_en_i) |=> (!pend_q && !irq_o)); // R3
  AST_UNPACED_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active && evt_i && any_en_i) |=> irq_o); // R4 R7
endmodule

// File: rtl/paced_irq_agg.sv
module paced_irq_agg
  import paced_irq_pkg::*;
#(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned MISC_W  = 4,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned PRESC_W = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CH-1:0]  rx_evt_i,
  input  logic [NUM_CH-1:0]  tx_evt_i,
  input  logic [NUM_CH-1:0]  thr_evt_i,
  input  logic [MISC_W-1:0]  misc_evt_i,
  input  logic [NUM_CH-1:0]  rx_en_i,
  input  logic [NUM_CH-1:0]  tx_en_i,
  input  logic [NUM_CH-1:0]  thr_en_i,
  input  logic [MISC_W-1:0]  misc_en_i,
  input  logic               pace_en_i,
  input  logic [CNT_W-1:0]   rx_max_i,
  input  logic [CNT_W-1:0]   tx_max_i,
  input  logic [PRESC_W-1:0] tick_cycles_i,
  output logic               rx_irq_o,
  output logic               tx_irq_o,
  output logic               thr_irq_o,
  output logic               misc_irq_o
);
  logic                tick;
  logic [NUM_CH-1:0]   dir_evt [NUM_DIR];
  logic [NUM_CH-1:0]   dir_en  [NUM_DIR];
  logic [CNT_W-1:0]    dir_max [NUM_DIR];
  logic [NUM_DIR-1:0]  dir_hit, dir_any, dir_irq;
  logic                thr_any, misc_any;

  assign dir_evt[DIR_RX] = rx_evt_i;
  assign dir_evt[DIR_TX] = tx_evt_i;
  assign dir_en[DIR_RX]  = rx_en_i;
  assign dir_en[DIR_TX]  = tx_en_i;
  assign dir_max[DIR_RX] = rx_max_i;
  assign dir_max[DIR_TX] = tx_max_i;

  window_timer #(.PRESC_W(PRESC_W)) u_timer (
    .clk_i, .rst_ni, .tick_cycles_i, .tick_o(tick)
  );

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    evt_gate #(.W(NUM_CH), .REG_OUT(1'b0)) u_gate (
      .clk_i, .rst_ni,
      .evt_i(dir_evt[d]), .en_i(dir_en[d]),
      .hit_o(dir_hit[d]), .any_en_o(dir_any[d])
    );
    rate_pacer #(.CNT_W(CNT_W)) u_pacer (
      .clk_i, .rst_ni, .tick_i(tick), .pace_en_i,
      .max_i(dir_max[d]), .evt_i(dir_hit[d]), .any_en_i(dir_any[d]),
      .irq_o(dir_irq[d])
    );
  end

  evt_gate #(.W(NUM_CH), .REG_OUT(1'b1)) u_thr (
    .clk_i, .rst_ni, .evt_i(thr_evt_i), .en_i(thr_en_i),
    .hit_o(thr_irq_o), .any_en_o(thr_any)
  );
  evt_gate #(.W(MISC_W), .REG_OUT(1'b1)) u_misc (
    .clk_i, .rst_ni, .evt_i(misc_evt_i), .en_i(misc_en_i),
    .hit_o(misc_irq_o), .any_en_o(misc_any)
  );

  assign rx_irq_o = dir_irq[DIR_RX];
  assign tx_irq_o = dir_irq[DIR_TX];

  AST_RX_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_i == '0) |=> !rx_irq_o); // R3
  AST_TX_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i == '0) |=> !tx_irq_o); // R3
  AST_THR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!thr_any) |=> !thr_irq_o); // R8
  AST_MISC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!misc_any) |=> !misc_irq_o); // R8
endmodule

// File: tb/paced_irq_agg_test.sv
module paced_irq_agg_test;
  localparam int NUM_CH = 8, MISC_W = 4, CNT_W = 8, PRESC_W = 20;
  localparam int N = 16;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [NUM_CH-1:0] rx_evt = '0, tx_evt = '0, thr_evt = '0;
  logic [MISC_W-1:0] misc_evt = '0;
  logic [NUM_CH-1:0] rx_en = '1, tx_en = '1, thr_en = '1;
  logic [MISC_W-1:0] misc_en = '1;
  logic pace_en = 1'b0;
  logic [CNT_W-1:0] rx_max = '0, tx_max = '0;
  logic [PRESC_W-1:0] tick_cycles = PRESC_W'(N);
  logic rx_irq, tx_irq, thr_irq, misc_irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  paced_irq_agg #(.NUM_CH(NUM_CH), .MISC_W(MISC_W), .CNT_W(CNT_W), .PRESC_W(PRESC_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .rx_evt_i(rx_evt), .tx_evt_i(tx_evt), .thr_evt_i(thr_evt), .misc_evt_i(misc_evt),
    .rx_en_i(rx_en), .tx_en_i(tx_en), .thr_en_i(thr_en), .misc_en_i(misc_en),
    .pace_en_i(pace_en), .rx_max_i(rx_max), .tx_max_i(tx_max),
    .tick_cycles_i(tick_cycles),
    .rx_irq_o(rx_irq), .tx_irq_o(tx_irq), .thr_irq_o(thr_irq), .misc_irq_o(misc_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    rx_evt = '0; tx_evt = '0; thr_evt = '0; misc_evt = '0;
    rx_en = '1; tx_en = '1; thr_en = '1; misc_en = '1;
    pace_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // stream rx with max 1 until a tick-driven delivery is seen
  task automatic align_rx();
    pace_en = 1'b1; rx_max = 8'd1; rx_evt = 8'h01;
    for (int k = 0; k < 2; k++) begin
      for (int c = 0; c < 4 * N; c++) begin
        @(negedge clk);
        if (rx_irq) break;
      end
    end
    rx_evt = '0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 rx in reset", rx_irq, 0);
    chk("R1 thr in reset", thr_irq, 0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 outputs after reset", {rx_irq, tx_irq, thr_irq, misc_irq}, 0);
  endtask

  task automatic t_unpaced();
    int hits = 0;
    pace_en = 1'b0; rx_max = 8'd1; rx_evt = 8'h10;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      hits += rx_irq;
    end
    chk("R4 unpaced every cycle", hits, 20);
    rx_evt = '0;
    @(negedge clk);
    chk("R4 idle after stream", rx_irq, 0);
  endtask

  task automatic t_cap();
    int rx_hits = 0, tx_hits = 0;
    idle();
    pace_en = 1'b1; rx_max = 8'd3; tx_max = 8'd2;
    rx_evt = 8'h01; tx_evt = 8'h80;
    repeat (2 * N) @(negedge clk);
    for (int i = 0; i < 4 * N; i++) begin
      @(negedge clk);
      rx_hits += rx_irq;
      tx_hits += tx_irq;
    end
    chk("R5 rx capped per window", rx_hits, 12);
    chk("R9 tx own cap", tx_hits, 8);
    idle();
  endtask

  task automatic t_hold();
    int got_at = -1, extra = 0;
    idle();
    align_rx();
    for (int i = 1; i <= 2 * N; i++) begin
      rx_evt = (i <= 3) ? 8'h02 : 8'h00;
      @(negedge clk);
      if (rx_irq) begin
        if (got_at < 0) got_at = i;
        else extra++;
      end
    end
    chk("R2 R6 held delivered one window later", got_at, N);
    chk("R6 held events collapse", extra, 0);
    idle();
  endtask

  task automatic t_drop();
    int hits = 0;
    idle();
    align_rx();
    for (int i = 1; i <= 2 * N; i++) begin
      rx_evt = (i == 1) ? 8'h01 : 8'h00;
      if (i >= 2) rx_en = '0;
      @(negedge clk);
      hits += rx_irq;
    end
    rx_en = '1;
    for (int i = 0; i < N + 2; i++) begin
      @(negedge clk);
      hits += rx_irq;
    end
    chk("R3 held request discarded on disable", hits, 0);
    idle();
  endtask

  task automatic t_zero_max();
    int rx_hits = 0, tx_hits = 0;
    idle();
    pace_en = 1'b1; rx_max = 8'd0; tx_max = 8'd1;
    rx_evt = 8'h04; tx_evt = 8'h04;
    repeat (2 * N) @(negedge clk);
    for (int i = 0; i < 4 * N; i++) begin
      @(negedge clk);
      rx_hits += rx_irq;
      tx_hits += tx_irq;
    end
    chk("R7 max zero unpaced", rx_hits, 4 * N);
    chk("R9 tx paced beside free rx", tx_hits, 4);
    idle();
  endtask

  task automatic t_masked();
    idle();
    rx_en = 8'hFE; tx_en = '0;
    rx_evt = 8'h01; tx_evt = 8'hFF;
    @(negedge clk);
    chk("R3 masked rx channel", rx_irq, 0);
    chk("R3 masked tx", tx_irq, 0);
    rx_evt = 8'h02;
    @(negedge clk);
    chk("R3 enabled neighbour passes", rx_irq, 1);
    idle();
  endtask

  task automatic t_thr_misc();
    int hits = 0;
    idle();
    pace_en = 1'b1; rx_max = 8'd1;
    thr_en = 8'h20; thr_evt = 8'h10;
    @(negedge clk);
    chk("R8 thr disabled channel", thr_irq, 0);
    thr_evt = 8'h20;
    @(negedge clk);
    chk("R8 thr next cycle", thr_irq, 1);
    thr_evt = '0;
    @(negedge clk);
    chk("R8 thr pulse ends", thr_irq, 0);
    misc_en = 4'b0100; misc_evt = 4'b1011;
    @(negedge clk);
    chk("R8 misc disabled", misc_irq, 0);
    misc_evt = 4'b0100;
    for (int i = 0; i < 3 * N; i++) begin
      @(negedge clk);
      hits += misc_irq;
    end
    chk("R8 misc not paced", hits, 3 * N);
    idle();
  endtask

  initial begin
    t_reset();
    t_unpaced();
    t_cap();
    t_hold();
    t_drop();
    t_zero_max();
    t_masked();
    t_thr_misc();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule